// File: doc/BRIEF.md
# Recursive Vertical-Crosswise Multiplier

This block multiplies two unsigned operands of `WIDTH` bits and returns their full product of `2*WIDTH` bits. It has no clock, no registers and no reset. The product settles combinationally from the operands.

The structure is recursive. At every level each operand is split into a low half and a high half. Four half-width multipliers form the low×low, high×low, low×high and high×high sub-products. Three ripple-carry adders then merge these into the full-width result:

- The first adder sums the two cross terms and keeps their carry.
- The second adder places that sum at the quarter-width offset, on top of the concatenated outer products.
- The third adder ripples the remaining carry into the top quarter.

The recursion ends in a 2×2 cell. That cell is built from four AND gates and two half adders.

`WIDTH` must be a power of two from 2 to 64. The block can be dropped into a datapath wherever an exact unsigned product is needed within one cycle.

Top module: `vcm_mult`

## Requirements
- R1: `p` equals the unsigned product `a*b`, exact over all `2*WIDTH` bits, for every operand pair.
- R2: When either operand is zero, `p` is zero.
- R3: When either operand equals 1, `p` equals the other operand, zero-extended to `2*WIDTH` bits.
- R4: When both operands are all ones, `p` equals `2^(2W) - 2^(W+1) + 1`. For example, with W=16 this is 0xFFFE0001.
- R5: When one operand is all ones and the other is `x`, `p` equals `x*2^W - x`.
- R6: When `a` equals `2^k`, `p` equals `b` shifted left by `k` bit positions.
- R7: Bit 0 of `p` equals `a[0] & b[0]`.
- R8: R1 holds in the same way at widths 4 and 64, the smallest recursive width and the largest supported width.
- R9: Swapping `a` and `b` leaves `p` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | Unsigned multiplicand |
| b | input | WIDTH | Unsigned multiplier |
| p | output | 2*WIDTH | Unsigned product |

## Verification
The hardest case is a carry that the second adder produces and the third adder must carry across the whole top quarter. That only happens when both cross products and the upper part of the low product are nearly full at the same time. Uniform random operands rarely line this up. The stimulus therefore adds directed all-ones operands, all-ones against random values, and powers of two. The 4-bit instance is swept exhaustively, so every carry pattern at the first recursive level is covered. The 64-bit instance exercises the deepest chains.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
    // Operand width at which the recursion stops in a gate-level cell.
    localparam int unsigned CELL_W = 2;
endpackage

// File: rtl/vcm_rca.sv
// Ripple-carry adder of N bits, carry-in tied low; callers widen operands to keep carries.
module vcm_rca #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] y,
    output logic [N-1:0] s
);
    logic [N-1:0] c;

    assign c[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign s[i] = x[i] ^ y[i] ^ c[i];
        if (i < N - 1) begin : g_carry
            assign c[i+1] = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
        end
    end
endmodule

// File: rtl/vcm_cell2.sv
// 2x2 base cell: four AND terms, two half adders.
module vcm_cell2 (
    input  logic [1:0] a,
    input  logic [1:0] b,
    output logic [3:0] p
);
    logic t00, t10, t01, t11;
    logic k_cross;

    always_comb begin
        t00     = a[0] & b[0];
        t10     = a[1] & b[0];
        t01     = a[0] & b[1];
        t11     = a[1] & b[1];
        k_cross = t10 & t01;
        p[0]    = t00;
        p[1]    = t10 ^ t01;
        p[2]    = t11 ^ k_cross;
        p[3]    = t11 & k_cross;
    end
endmodule

// File: rtl/vcm_node.sv
// One recursion level: four half-width products merged by three ripple adders.
module vcm_node #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    localparam int unsigned H = W / 2;

    if (W == vcm_pkg::CELL_W) begin : g_leaf
        vcm_cell2 u_cell (
            .a (a),
            .b (b),
            .p (p)
        );
    end else begin : g_split
        logic [W-1:0] pr_ll, pr_hl, pr_lh, pr_hh;
        logic [W:0]   cross_sum;
        logic [W+1:0] mid_sum;
        logic [H-1:0] top_sum;
        logic [H-1:0] top_inc;

        vcm_node #(.W(H)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(pr_ll));
        vcm_node #(.W(H)) u_hl (.a(a[W-1:H]), .b(b[H-1:0]), .p(pr_hl));
        vcm_node #(.W(H)) u_lh (.a(a[H-1:0]), .b(b[W-1:H]), .p(pr_lh));
        vcm_node #(.W(H)) u_hh (.a(a[W-1:H]), .b(b[W-1:H]), .p(pr_hh));

        // Adder 1: cross terms, carry kept.
        vcm_rca #(.N(W+1)) u_add_cross (
            .x ({1'b0, pr_hl}),
            .y ({1'b0, pr_lh}),
            .s (cross_sum)
        );

        // Adder 2: cross sum onto {HH low half, LL high half}.
        vcm_rca #(.N(W+2)) u_add_mid (
            .x ({2'b00, pr_hh[H-1:0], pr_ll[W-1:H]}),
            .y ({1'b0, cross_sum}),
            .s (mid_sum)
        );

        assign top_inc = H'(mid_sum[W+1:W]);

        // Adder 3: leftover carry into the top quarter.
        vcm_rca #(.N(H)) u_add_top (
            .x (pr_hh[W-1:H]),
            .y (top_inc),
            .s (top_sum)
        );

        assign p = {top_sum, mid_sum[W-1:0], pr_ll[H-1:0]};
    end
endmodule

// File: rtl/vcm_mult.sv
module vcm_mult #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    output logic [2*WIDTH-1:0] p
);
    vcm_node #(.W(WIDTH)) u_root (
        .a (a),
        .b (b),
        .p (p)
    );
endmodule

// File: rtl/vcm_mult_chk.sv
module vcm_mult_chk #(
    parameter int unsigned WIDTH = 16
) (
    input logic [WIDTH-1:0]   a,
    input logic [WIDTH-1:0]   b,
    input logic [2*WIDTH-1:0] p
);
    localparam int unsigned PW = 2 * WIDTH;

    logic [PW-1:0] ref_prod;
    logic [PW-1:0] a_ext, b_ext;

    always_comb begin
        a_ext    = {{WIDTH{1'b0}}, a};
        b_ext    = {{WIDTH{1'b0}}, b};
        ref_prod = a_ext * b_ext;

        assert_exact_R1: assert (p == ref_prod)
            else $error("R1 product mismatch");

        if (a == '0 || b == '0) begin
            assert_zero_R2: assert (p == '0)
                else $error("R2 zero operand gave nonzero product");
        end

        if (a == WIDTH'(1)) begin
            assert_unit_R3: assert (p == b_ext)
                else $error("R3 unit operand");
        end

        if (a == '1) begin
            assert_ones_R5: assert (p == ((b_ext << WIDTH) - b_ext))
                else $error("R5 all-ones operand");
        end

        assert_lsb_R7: assert (p[0] == (a[0] & b[0]))
            else $error("R7 lsb");
    end
endmodule

bind vcm_mult vcm_mult_chk #(.WIDTH(WIDTH)) u_chk (.a(a), .b(b), .p(p));

// File: tb/vcm_mult_tb.sv
module vcm_mult_tb;
    localparam int unsigned W  = 16;
    localparam int unsigned WS = 4;
    localparam int unsigned WL = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [W-1:0]    a, b;
    logic [2*W-1:0]  p;
    logic [WS-1:0]   as, bs;
    logic [2*WS-1:0] ps;
    logic [WL-1:0]   al, bl;
    logic [2*WL-1:0] pl;

    int unsigned n_vec  = 0;
    int unsigned n_miss = 0;

    vcm_mult #(.WIDTH(W))  u_dut   (.a(a),  .b(b),  .p(p));
    vcm_mult #(.WIDTH(WS)) u_small (.a(as), .b(bs), .p(ps));
    vcm_mult #(.WIDTH(WL)) u_wide  (.a(al), .b(bl), .p(pl));

    function automatic logic [2*W-1:0] exp_mul(logic [W-1:0] x, logic [W-1:0] y);
        logic [2*W-1:0] acc = '0;
        for (int i = 0; i < W; i++)
            if (y[i]) acc = acc + ({{W{1'b0}}, x} << i);
        return acc;
    endfunction

    function automatic logic [2*WL-1:0] exp_mul_l(logic [WL-1:0] x, logic [WL-1:0] y);
        logic [2*WL-1:0] acc = '0;
        for (int i = 0; i < WL; i++)
            if (y[i]) acc = acc + ({{WL{1'b0}}, x} << i);
        return acc;
    endfunction

    task automatic chk(string req, logic [2*WL-1:0] act, logic [2*WL-1:0] expv);
        n_vec++;
        if (act !== expv) begin
            n_miss++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic run16(string req, logic [W-1:0] x, logic [W-1:0] y, logic [2*W-1:0] expv);
        @(negedge clk);
        a = x; b = y;
        @(posedge clk);
        chk(req, {{(2*WL-2*W){1'b0}}, p}, {{(2*WL-2*W){1'b0}}, expv});
    endtask

    initial begin
        a = '0; b = '0; as = '0; bs = '0; al = '0; bl = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Reset / idle state: zero inputs give zero product (R2)
        @(negedge clk);
        chk("R2", {{(2*WL-2*W){1'b0}}, p}, '0);

        // Directed corners
        run16("R2", '0, 16'hBEEF, '0);
        run16("R2", 16'h1234, '0, '0);
        run16("R3", 16'd1, 16'hA5C3, 32'h0000A5C3);
        run16("R3", 16'hFFFF, 16'd1, 32'h0000FFFF);
        run16("R4", '1, '1, 32'hFFFE0001);
        run16("R5", '1, 16'h8001, ({16'h0, 16'h8001} << 16) - {16'h0, 16'h8001});
        run16("R5", '1, 16'h7FFF, ({16'h0, 16'h7FFF} << 16) - {16'h0, 16'h7FFF});
        for (int k = 0; k < W; k++) begin
            logic [W-1:0] r = W'($urandom);
            run16("R6", W'(1) << k, r, {16'h0, r} << k);
        end
        run16("R1", 16'h00FF, 16'h00FF, 32'h0000FE01);
        run16("R1", 16'hFF00, 16'hFF00, 32'hFE010000);

        // Random: exact product, lsb and operand swap
        for (int i = 0; i < 2000; i++) begin
            logic [W-1:0] x = W'($urandom);
            logic [W-1:0] y = W'($urandom);
            logic [2*W-1:0] e = exp_mul(x, y);
            if (i % 4 == 0) x = x | 16'hFF00;
            e = exp_mul(x, y);
            run16("R1", x, y, e);
            chk("R7", {{(2*WL-1){1'b0}}, p[0]}, {{(2*WL-1){1'b0}}, x[0] & y[0]});
            run16("R9", y, x, e);
        end

        // Width 4: exhaustive (R8)
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                @(negedge clk);
                as = WS'(i); bs = WS'(j);
                @(posedge clk);
                chk("R8", {{(2*WL-8){1'b0}}, ps}, {{(2*WL-8){1'b0}}, 8'(i * j)});
            end
        end

        // Width 64: corners and random (R8)
        @(negedge clk);
        al = '1; bl = '1;
        @(posedge clk);
        chk("R8", pl, exp_mul_l('1, '1));
        for (int i = 0; i < 300; i++) begin
            logic [WL-1:0] x = {$urandom, $urandom};
            logic [WL-1:0] y = {$urandom, $urandom};
            if (i % 3 == 0) x = '1;
            @(negedge clk);
            al = x; bl = y;
            @(posedge clk);
            chk("R8", pl, exp_mul_l(x, y));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_miss++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end
endmodule